// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the part of an I2C master that takes over the bus once a byte has moved. On request it clocks out the acknowledge bit for a received byte, or it ends the transfer with a stop condition. Both lines are open-drain. The block only asserts drive-low enables and reads the real line levels back. Each phase lasts one baud period, set by a programmable reload value. Before the next period starts, the block waits until the line it just released actually reads high. A slave can therefore stretch the clock for as long as it needs.

Software starts a sequence with a one-cycle request strobe. The matching enable output stays high while the sequence runs and clears itself at the end, when a sticky interrupt flag is raised. Writes to the transmit buffer while a sequence runs are refused and flagged. A sticky stop-detected flag records a stop seen on the lines. Start generation, data shifting and address matching belong to other blocks.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After synchronous reset, both drive enables are 0 (lines released), all flags and both enables are 0, and the buffer holds 0.
- R2: An acknowledge request accepted in idle makes `ack_en_o` 1 and `scl_drv_o` 1 on the next cycle. `sda_drv_o` is then 1 when `ack_bit_i` was 0 (acknowledge) and 0 when it was 1 (not-acknowledge). SDA stays at that level until the sequence ends.
- R3: Each counted phase lasts reload+1 cycles. After the first SCL-low phase, SCL is released. The SCL-high phase is not counted until `scl_in_i` reads 1, so a stretched clock keeps the sequence waiting with SCL released.
- R4: After the SCL-high phase, SCL is driven low for one cycle with SDA unchanged. The block then returns to idle: SDA is released, SCL stays driven low, `ack_en_o` clears and `irq_o` is set.
- R5: A stop request accepted in idle makes `stop_en_o`, `scl_drv_o` and `sda_drv_o` 1 on the next cycle. SCL is held low for one period, counted from the cycle in which SDA reads low.
- R6: During a stop, SCL is released first. Once it reads high, one period is counted and then SDA is released. SDA is never released while SCL is driven.
- R7: When SDA and SCL both read high after SDA is released, `stopdet_o` is set. One period later `stop_en_o` clears, `irq_o` is set, and both lines stay released.
- R8: A buffer write while a sequence is busy sets `wcol_o` and leaves `buf_q_o` unchanged. A write in idle loads `buf_q_o` on the next cycle.
- R9: `wcol_o`, `stopdet_o` and `irq_o` stay set until their clear strobe. A set and a clear in the same cycle leave the flag set.
- R10: Acknowledge and stop requested in the same cycle start the acknowledge. Requests made while a sequence is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_i | input | BAUD_W | Baud reload; one period is reload+1 cycles |
| ack_req_i | input | 1 | Start acknowledge sequence (strobe) |
| ack_bit_i | input | 1 | Acknowledge value: 0 acknowledge, 1 not-acknowledge |
| stop_req_i | input | 1 | Start stop sequence (strobe) |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | DATA_W | Buffer write data |
| wcol_clr_i | input | 1 | Clear write-collision flag |
| stopdet_clr_i | input | 1 | Clear stop-detected flag |
| irq_clr_i | input | 1 | Clear interrupt flag |
| scl_in_i | input | 1 | Sampled SCL line level |
| sda_in_i | input | 1 | Sampled SDA line level |
| scl_drv_o | output | 1 | 1 pulls SCL low |
| sda_drv_o | output | 1 | 1 pulls SDA low |
| ack_en_o | output | 1 | Acknowledge sequence in progress |
| stop_en_o | output | 1 | Stop sequence in progress |
| buf_q_o | output | DATA_W | Transmit buffer contents |
| wcol_o | output | 1 | Write-collision flag |
| stopdet_o | output | 1 | Stop-detected flag |
| irq_o | output | 1 | Sequence-done interrupt flag |

## Verification
The bench holds SCL low after release, both during an acknowledge and during a stop. A sequencer that counted through the stretch would release SDA or re-drive SCL early, and the per-cycle comparison would catch it. It measures the first SCL-low phase against reload+1, using reload values of 0, 2 and 3, so an off-by-one counter shows up as a wrong length. It writes the buffer, requests a stop, and sets and clears a flag in the same cycle, all while a sequence runs. A design that let the write through, started a second sequence, or let the clear win would show a changed buffer, a raised stop enable or a dropped flag. A simultaneous request checks that the acknowledge wins.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_A_LOW,
    ST_A_REL,
    ST_A_HIGH,
    ST_A_TAIL,
    ST_P_SDA,
    ST_P_LOW,
    ST_P_REL,
    ST_P_HIGH,
    ST_P_SDAR,
    ST_P_DONE
  } seq_st_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_drv_t;

  // Line pull-down enables for each state.
  function automatic line_drv_t drive_for(seq_st_e st, logic ackd, logic hold);
    line_drv_t d;
    unique case (st)
      ST_IDLE:   d = '{scl: hold, sda: 1'b0};
      ST_A_LOW:  d = '{scl: 1'b1, sda: ~ackd};
      ST_A_REL:  d = '{scl: 1'b0, sda: ~ackd};
      ST_A_HIGH: d = '{scl: 1'b0, sda: ~ackd};
      ST_A_TAIL: d = '{scl: 1'b1, sda: ~ackd};
      ST_P_SDA:  d = '{scl: 1'b1, sda: 1'b1};
      ST_P_LOW:  d = '{scl: 1'b1, sda: 1'b1};
      ST_P_REL:  d = '{scl: 1'b0, sda: 1'b1};
      ST_P_HIGH: d = '{scl: 1'b0, sda: 1'b1};
      default:   d = '{scl: 1'b0, sda: 1'b0};
    endcase
    return d;
  endfunction

  function automatic logic is_counting(seq_st_e st);
    return (st == ST_A_LOW) || (st == ST_A_HIGH) || (st == ST_P_LOW) ||
           (st == ST_P_HIGH) || (st == ST_P_DONE);
  endfunction

endpackage

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] reload_i,
  input  logic         load_i,
  input  logic         run_i,
  output logic         tc_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load_i)              cnt <= reload_i;
    else if (run_i && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign tc_o = run_i && (cnt == '0);

endmodule

// File: rtl/i2c_seq_flags.sv
module i2c_seq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_req_i,
  input  logic ack_bit_i,
  input  logic stop_req_i,
  input  logic scl_in_i,
  input  logic sda_in_i,
  input  logic tc_i,
  output logic load_o,
  output logic run_o,
  output logic scl_drv_o,
  output logic sda_drv_o,
  output logic ack_en_o,
  output logic stop_en_o,
  output logic busy_o,
  output logic irq_set_o,
  output logic det_set_o
);
  seq_st_e   st, st_n;
  logic      ackd, ackd_n, hold, hold_n;
  line_drv_t drv_n;

  always_comb begin
    st_n      = st;
    ackd_n    = ackd;
    hold_n    = hold;
    load_o    = 1'b0;
    irq_set_o = 1'b0;
    det_set_o = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ack_req_i) begin
          st_n   = ST_A_LOW;
          ackd_n = ack_bit_i;
          load_o = 1'b1;
        end else if (stop_req_i) begin
          st_n = ST_P_SDA;
        end
      end
      ST_A_LOW:  if (tc_i) st_n = ST_A_REL;
      ST_A_REL:  if (scl_in_i) begin st_n = ST_A_HIGH; load_o = 1'b1; end
      ST_A_HIGH: if (tc_i) st_n = ST_A_TAIL;
      ST_A_TAIL: begin st_n = ST_IDLE; hold_n = 1'b1; irq_set_o = 1'b1; end
      ST_P_SDA:  if (!sda_in_i) begin st_n = ST_P_LOW; load_o = 1'b1; end
      ST_P_LOW:  if (tc_i) st_n = ST_P_REL;
      ST_P_REL:  if (scl_in_i) begin st_n = ST_P_HIGH; load_o = 1'b1; end
      ST_P_HIGH: if (tc_i) st_n = ST_P_SDAR;
      ST_P_SDAR: if (sda_in_i && scl_in_i) begin
        st_n = ST_P_DONE; load_o = 1'b1; det_set_o = 1'b1;
      end
      ST_P_DONE: if (tc_i) begin st_n = ST_IDLE; hold_n = 1'b0; irq_set_o = 1'b1; end
      default:   st_n = ST_IDLE;
    endcase
  end

  assign drv_n  = drive_for(st_n, ackd_n, hold_n);
  assign run_o  = is_counting(st);
  assign busy_o = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ackd      <= 1'b0;
      hold      <= 1'b0;
      scl_drv_o <= 1'b0;
      sda_drv_o <= 1'b0;
      ack_en_o  <= 1'b0;
      stop_en_o <= 1'b0;
    end else begin
      st        <= st_n;
      ackd      <= ackd_n;
      hold      <= hold_n;
      scl_drv_o <= drv_n.scl;
      sda_drv_o <= drv_n.sda;
      ack_en_o  <= (st_n inside {ST_A_LOW, ST_A_REL, ST_A_HIGH, ST_A_TAIL});
      stop_en_o <= (st_n inside {ST_P_SDA, ST_P_LOW, ST_P_REL, ST_P_HIGH,
                                 ST_P_SDAR, ST_P_DONE});
    end
  end

  // R10: the two sequences never overlap
  a_r10_one_seq: assert property (@(posedge clk) disable iff (rst)
    !(ack_en_o && stop_en_o));

  // R2: SDA holds its acknowledge level for the whole sequence
  a_r2_sda_steady: assert property (@(posedge clk) disable iff (rst)
    (ack_en_o && $past(ack_en_o)) |-> $stable(sda_drv_o));

  // R6: in a stop, SDA is released only while SCL is released
  a_r6_sda_after_scl: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_drv_o) && $past(stop_en_o)) |-> !scl_drv_o);

endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
  parameter int BAUD_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BAUD_W-1:0] reload_i,
  input  logic              ack_req_i,
  input  logic              ack_bit_i,
  input  logic              stop_req_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              wcol_clr_i,
  input  logic              stopdet_clr_i,
  input  logic              irq_clr_i,
  input  logic              scl_in_i,
  input  logic              sda_in_i,
  output logic              scl_drv_o,
  output logic              sda_drv_o,
  output logic              ack_en_o,
  output logic              stop_en_o,
  output logic [DATA_W-1:0] buf_q_o,
  output logic              wcol_o,
  output logic              stopdet_o,
  output logic              irq_o
);
  localparam int NFLAG = 3;

  logic load, run, tc, busy, irq_set, det_set;
  logic [NFLAG-1:0] fset, fclr, fq;

  i2c_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ack_req_i (ack_req_i),
    .ack_bit_i (ack_bit_i),
    .stop_req_i(stop_req_i),
    .scl_in_i  (scl_in_i),
    .sda_in_i  (sda_in_i),
    .tc_i      (tc),
    .load_o    (load),
    .run_o     (run),
    .scl_drv_o (scl_drv_o),
    .sda_drv_o (sda_drv_o),
    .ack_en_o  (ack_en_o),
    .stop_en_o (stop_en_o),
    .busy_o    (busy),
    .irq_set_o (irq_set),
    .det_set_o (det_set)
  );

  i2c_baud_timer #(.W(BAUD_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .reload_i(reload_i),
    .load_i  (load),
    .run_i   (run),
    .tc_o    (tc)
  );

  assign fset = {irq_set, det_set, buf_wr_i && busy};
  assign fclr = {irq_clr_i, stopdet_clr_i, wcol_clr_i};

  i2c_seq_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set_i (fset),
    .clr_i (fclr),
    .flag_o(fq)
  );

  assign wcol_o    = fq[0];
  assign stopdet_o = fq[1];
  assign irq_o     = fq[2];

  always_ff @(posedge clk) begin
    if (rst)                   buf_q_o <= '0;
    else if (buf_wr_i && !busy) buf_q_o <= buf_wdata_i;
  end

  // R4: the end of an acknowledge raises the interrupt
  a_r4_ack_irq: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_en_o) |-> irq_o);

  // R7: stop detection needs both lines reading high
  a_r7_det_lines: assert property (@(posedge clk) disable iff (rst)
    $rose(stopdet_o) |-> $past(sda_in_i && scl_in_i));

  // R8: a write during a sequence collides and is dropped
  a_r8_wcol: assert property (@(posedge clk) disable iff (rst)
    (buf_wr_i && (ack_en_o || stop_en_o)) |=> (wcol_o && $stable(buf_q_o)));

endmodule

// File: tb/tb_i2c_ackstop_seq.sv
module tb_i2c_ackstop_seq;
  localparam int BW = 8;
  localparam int DW = 8;

  logic clk = 0, rst = 1;
  logic [BW-1:0] reload = 3;
  logic ack_req = 0, ack_bit = 0, stop_req = 0, buf_wr = 0;
  logic [DW-1:0] wdata = 0;
  logic wcol_clr = 0, det_clr = 0, irq_clr = 0, stretch = 0;
  logic scl_in, sda_in;
  logic scl_drv, sda_drv, ack_en, stop_en, wcol, stopdet, irq;
  logic [DW-1:0] buf_q;

  int vec = 0, mis = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // open-drain bus with an optional clock-stretching slave
  assign scl_in = ~scl_drv & ~stretch;
  assign sda_in = ~sda_drv;

  i2c_ackstop_seq #(.BAUD_W(BW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .reload_i(reload), .ack_req_i(ack_req),
    .ack_bit_i(ack_bit), .stop_req_i(stop_req), .buf_wr_i(buf_wr),
    .buf_wdata_i(wdata), .wcol_clr_i(wcol_clr), .stopdet_clr_i(det_clr),
    .irq_clr_i(irq_clr), .scl_in_i(scl_in), .sda_in_i(sda_in),
    .scl_drv_o(scl_drv), .sda_drv_o(sda_drv), .ack_en_o(ack_en),
    .stop_en_o(stop_en), .buf_q_o(buf_q), .wcol_o(wcol),
    .stopdet_o(stopdet), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 ack low, 2 ack wait high, 3 ack high, 4 ack tail,
  //        5 stop wait sda, 6 stop low, 7 stop wait scl, 8 stop high,
  //        9 stop wait lines, 10 stop done
  int phase = 0, left = 0;
  bit m_ackd, m_hold, m_wcol, m_det, m_irq;
  logic [DW-1:0] m_buf;

  always @(posedge clk) begin
    if (rst) begin
      phase <= 0; left <= 0; m_ackd <= 0; m_hold <= 0;
      m_wcol <= 0; m_det <= 0; m_irq <= 0; m_buf <= '0;
    end else begin
      bit s_irq, s_det, s_wcol;
      s_irq = 0; s_det = 0; s_wcol = 0;
      if (buf_wr) begin
        if (phase != 0) s_wcol = 1;
        else m_buf <= wdata;
      end
      case (phase)
        0: if (ack_req) begin phase <= 1; m_ackd <= ack_bit; left <= int'(reload); end
           else if (stop_req) phase <= 5;
        1, 3, 6, 8, 10: begin
          if (left == 0) begin
            if (phase == 10) begin phase <= 0; m_hold <= 0; s_irq = 1; end
            else phase <= phase + 1;
          end else left <= left - 1;
        end
        2: if (scl_in) begin phase <= 3; left <= int'(reload); end
        4: begin phase <= 0; m_hold <= 1; s_irq = 1; end
        5: if (!sda_in) begin phase <= 6; left <= int'(reload); end
        7: if (scl_in) begin phase <= 8; left <= int'(reload); end
        9: if (sda_in && scl_in) begin phase <= 10; left <= int'(reload); s_det = 1; end
        default: phase <= 0;
      endcase
      m_wcol <= s_wcol ? 1'b1 : (wcol_clr ? 1'b0 : m_wcol);
      m_det  <= s_det  ? 1'b1 : (det_clr  ? 1'b0 : m_det);
      m_irq  <= s_irq  ? 1'b1 : (irq_clr  ? 1'b0 : m_irq);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit e_scl, e_sda;
      case (phase)
        0: begin e_scl = m_hold; e_sda = 0; end
        1, 4: begin e_scl = 1; e_sda = !m_ackd; end
        2, 3: begin e_scl = 0; e_sda = !m_ackd; end
        5, 6: begin e_scl = 1; e_sda = 1; end
        7, 8: begin e_scl = 0; e_sda = 1; end
        default: begin e_scl = 0; e_sda = 0; end
      endcase
      chk("R3 scl_drv", scl_drv, e_scl);
      chk("R2 sda_drv", sda_drv, e_sda);
      chk("R4 ack_en", ack_en, (phase >= 1 && phase <= 4));
      chk("R7 stop_en", stop_en, (phase >= 5));
      chk("R8 wcol", wcol, m_wcol);
      chk("R7 stopdet", stopdet, m_det);
      chk("R9 irq", irq, m_irq);
      chk("R8 buf_q", buf_q, m_buf);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(negedge clk); endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      step();
      if (!ack_en && !stop_en) return;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mis++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) step();
    rst = 0;
    step();
    // R1 reset state
    chk("R1 scl_drv", scl_drv, 0);
    chk("R1 sda_drv", sda_drv, 0);
    chk("R1 flags", {ack_en, stop_en, wcol, stopdet, irq}, 0);
    chk("R1 buf_q", buf_q, 0);

    // R2/R3: acknowledge with reload 3, measure SCL-low length
    reload = 3; ack_bit = 0; ack_req = 1;
    step(); ack_req = 0;
    chk("R2 ack_en", ack_en, 1);
    chk("R2 sda ack", sda_drv, 1);
    begin
      int n = 1;
      while (scl_drv && n < 100) begin step(); if (scl_drv) n++; end
      chk("R3 low length", n, 4);
    end
    wait_idle();
    chk("R4 irq", irq, 1);
    chk("R4 scl held", scl_drv, 1);
    chk("R4 sda released", sda_drv, 0);
    irq_clr = 1; step(); irq_clr = 0;
    chk("R9 irq cleared", irq, 0);

    // R2 not-acknowledge, R8 collision, R10 ignored stop, R3 stretch
    ack_bit = 1; ack_req = 1;
    step(); ack_req = 0;
    chk("R2 sda nack", sda_drv, 0);
    buf_wr = 1; wdata = 8'hA5; stop_req = 1;
    step(); buf_wr = 0; stop_req = 0;
    chk("R8 wcol set", wcol, 1);
    chk("R8 buf unchanged", buf_q, 0);
    while (scl_drv) step();
    stretch = 1;
    repeat (6) begin step(); chk("R3 stretch wait", {scl_drv, ack_en}, 2'b01); end
    stretch = 0;
    wait_idle();
    repeat (3) begin step(); chk("R10 busy stop ignored", stop_en, 0); end

    // R9 set beats clear; reload 0
    reload = 0; ack_bit = 0; ack_req = 1;
    step(); ack_req = 0;
    buf_wr = 1; wcol_clr = 1; wdata = 8'h11;
    step(); buf_wr = 0;
    chk("R9 set wins", wcol, 1);
    step(); wcol_clr = 0;
    chk("R9 wcol cleared", wcol, 0);
    wait_idle();

    // R8 idle write
    buf_wr = 1; wdata = 8'h3C;
    step(); buf_wr = 0;
    chk("R8 idle write", buf_q, 8'h3C);
    irq_clr = 1; step(); irq_clr = 0;

    // R5/R6/R7 stop with stretch, reload 2
    reload = 2; stop_req = 1;
    step(); stop_req = 0;
    chk("R5 stop start", {stop_en, scl_drv, sda_drv}, 3'b111);
    while (scl_drv) step();
    stretch = 1;
    repeat (4) begin step(); chk("R6 sda held", sda_drv, 1); end
    stretch = 0;
    wait_idle();
    chk("R7 stopdet", stopdet, 1);
    chk("R7 irq", irq, 1);
    chk("R7 lines released", {scl_drv, sda_drv}, 0);

    // R10 simultaneous requests
    irq_clr = 1; ack_req = 1; stop_req = 1;
    step(); ack_req = 0; stop_req = 0; irq_clr = 0;
    chk("R10 ack first", {ack_en, stop_en}, 2'b10);
    wait_idle();
    det_clr = 1; step(); det_clr = 0;
    chk("R9 stopdet cleared", stopdet, 0);

    repeat (3) step();
    finish_run();
  end
endmodule